// File: doc/BRIEF.md
# PLL Lock Status Qualifier

This block decides when a phase-locked loop may report itself as locked. A raw frequency-lock flag from the analog loop is trusted only after it has stayed high, without a break, for a long run of reference clock cycles. Short lock episodes during frequency transitions therefore never reach the outside. The qualified result drives two outputs, one for a package pin and one for a readable status bit. Both come from the same next-state value and toggle together.

Lock is withdrawn as soon as the raw flag falls, or when the control logic reports a feedback divider change, a pre-divider change or a frequency step command. It is also withdrawn when the reference clock stops. A watchdog on a free-running system clock catches the stopped reference: a toggle flop in the reference domain, after synchronization, reloads the watchdog on every reference edge. After any loss, qualification starts again by itself. All control logic runs on the system clock. Only the toggle flop runs on the reference clock.

Top module: `pll_lock_qualifier`

## Requirements
- R1: `lockPin` and `lockBit` carry the same value on every system clock cycle.
- R2: Lock rises only after `QUAL_CYCLES` reference cycles (default 256) have been counted while the synchronized raw lock flag stayed high. It rises on the system clock edge after the last of those cycles is seen.
- R3: A fall of the raw lock flag while qualification is running resets the reference-cycle count to zero. The full `QUAL_CYCLES` run is needed again after the flag returns.
- R4: A fall of the raw lock flag while locked clears lock. `rawLock` is asynchronous and passes through a `SYNC_STAGES` flop synchronizer, then lock clears on the following system edge.
- R5: A one-cycle high pulse on `fbDivChg` clears lock on the next system clock edge and restarts qualification from zero.
- R6: A one-cycle high pulse on `preDivChg` clears lock on the next system clock edge and restarts qualification from zero.
- R7: A one-cycle high pulse on `stepCmd` clears lock on the next system clock edge and restarts qualification from zero.
- R8: When no reference edge arrives for `WDOG_LIMIT` system cycles, lock clears. This limit is set to two reference periods. A single missing reference edge does not clear lock.
- R9: After any loss of lock, qualification restarts on its own once the raw flag is high and reference edges arrive. Lock returns after the qualifying count with no other input.
- R10: An active-high asynchronous `rst` forces both lock outputs low at once and clears all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Free-running system clock; clocks all control, counters and outputs |
| refClk | input | 1 | PLL reference clock being supervised |
| rst | input | 1 | Active-high asynchronous reset |
| rawLock | input | 1 | Raw frequency-lock flag from the loop, asynchronous |
| fbDivChg | input | 1 | One-cycle pulse (sysClk domain): feedback divider changed |
| preDivChg | input | 1 | One-cycle pulse (sysClk domain): pre-divider changed |
| stepCmd | input | 1 | One-cycle pulse (sysClk domain): frequency increment/decrement issued |
| lockPin | output | 1 | Qualified lock for the package pin |
| lockBit | output | 1 | Qualified lock for the status register bit |

## Verification
The bench builds the block with `QUAL_CYCLES` = 16 and `WDOG_LIMIT` = 16, and runs the reference at one eighth of the system clock, so the watchdog limit is exactly two reference periods. The short qualification window makes it possible to sweep a raw-lock dropout and each of the three restart pulses across every reference cycle position inside the window. Every such case is then followed by a full relock. Each relock is checked against lower and upper arithmetic bounds derived from the reference period and the synchronizer depth. Stopping the reference then probes both sides of the watchdog: still locked after one missing edge, and unlocked after two.

// File: rtl/lock_qual_pkg.sv
package lock_qual_pkg;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } lock_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic qualClr;
    logic qualEn;
  } ctl_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic refTick;
    logic qualLast;
    logic refLost;
    logic rawOk;
  } dp_status_t;

endpackage

// File: rtl/lock_qual_sync.sv
module lock_qual_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lock_qual_datapath.sv
module lock_qual_datapath
  import lock_qual_pkg::*;
#(
  parameter int QUAL_CYCLES = 256,
  parameter int WDOG_LIMIT  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        sysClk,
  input  logic        refClk,
  input  logic        rst,
  input  logic        rawLock,
  input  ctl_strobe_t strobe,
  output dp_status_t  status
);

  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam int WW = $clog2(WDOG_LIMIT + 1);
  localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_CYCLES - 1);
  localparam logic [WW-1:0] WDOG_TOP  = WW'(WDOG_LIMIT);

  // reference domain: one toggle per reference rising edge
  logic refTgl;
  always_ff @(posedge refClk or posedge rst) begin
    if (rst) refTgl <= 1'b0;
    else     refTgl <= ~refTgl;
  end

  logic tglSync, tglPrev, rawSync;

  lock_qual_sync #(.STAGES(SYNC_STAGES)) u_tglSync (
    .clk(sysClk), .rst(rst), .d(refTgl), .q(tglSync)
  );

  lock_qual_sync #(.STAGES(SYNC_STAGES)) u_rawSync (
    .clk(sysClk), .rst(rst), .d(rawLock), .q(rawSync)
  );

  always_ff @(posedge sysClk or posedge rst) begin
    if (rst) tglPrev <= 1'b0;
    else     tglPrev <= tglSync;
  end

  logic refTick;
  assign refTick = tglSync ^ tglPrev;

  // watchdog: reloads on each reference tick, saturates at the limit
  logic [WW-1:0] wdCnt;
  always_ff @(posedge sysClk or posedge rst) begin
    if (rst)                  wdCnt <= '0;
    else if (refTick)         wdCnt <= '0;
    else if (wdCnt != WDOG_TOP) wdCnt <= wdCnt + 1'b1;
  end

  // qualification counter in reference cycles
  logic [QW-1:0] qualCnt;
  always_ff @(posedge sysClk or posedge rst) begin
    if (rst)                 qualCnt <= '0;
    else if (strobe.qualClr) qualCnt <= '0;
    else if (strobe.qualEn)  qualCnt <= qualCnt + 1'b1;
  end

  always_comb begin
    status.refTick  = refTick;
    status.qualLast = refTick && (qualCnt == QUAL_LAST);
    status.refLost  = (wdCnt == WDOG_TOP);
    status.rawOk    = rawSync;
  end

endmodule

// File: rtl/lock_qual_control.sv
module lock_qual_control
  import lock_qual_pkg::*;
(
  input  logic        sysClk,
  input  logic        rst,
  input  dp_status_t  status,
  input  logic        fbDivChg,
  input  logic        preDivChg,
  input  logic        stepCmd,
  output ctl_strobe_t strobe,
  output logic        lockPinQ,
  output logic        lockBitQ
);

  lock_state_t state, stateNext;
  logic restartReq, dropNow;

  assign restartReq = fbDivChg | preDivChg | stepCmd;
  assign dropNow    = restartReq | status.refLost | ~status.rawOk;

  always_comb begin
    stateNext = state;
    if (dropNow)
      stateNext = ST_HUNT;
    else if (state == ST_HUNT && status.qualLast)
      stateNext = ST_LOCKED;
  end

  always_comb begin
    strobe.qualClr = dropNow | (state == ST_LOCKED);
    strobe.qualEn  = ~dropNow & (state == ST_HUNT) & status.refTick;
  end

  always_ff @(posedge sysClk or posedge rst) begin
    if (rst) begin
      state    <= ST_HUNT;
      lockPinQ <= 1'b0;
      lockBitQ <= 1'b0;
    end else begin
      state    <= stateNext;
      lockPinQ <= (stateNext == ST_LOCKED);
      lockBitQ <= (stateNext == ST_LOCKED);
    end
  end

endmodule

// File: rtl/pll_lock_qualifier.sv
module pll_lock_qualifier
  import lock_qual_pkg::*;
#(
  parameter int QUAL_CYCLES = 256,
  parameter int WDOG_LIMIT  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic sysClk,
  input  logic refClk,
  input  logic rst,
  input  logic rawLock,
  input  logic fbDivChg,
  input  logic preDivChg,
  input  logic stepCmd,
  output logic lockPin,
  output logic lockBit
);

  ctl_strobe_t strobe;
  dp_status_t  dpStat;

  lock_qual_datapath #(
    .QUAL_CYCLES(QUAL_CYCLES),
    .WDOG_LIMIT (WDOG_LIMIT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .sysClk (sysClk),
    .refClk (refClk),
    .rst    (rst),
    .rawLock(rawLock),
    .strobe (strobe),
    .status (dpStat)
  );

  lock_qual_control u_ctl (
    .sysClk   (sysClk),
    .rst      (rst),
    .status   (dpStat),
    .fbDivChg (fbDivChg),
    .preDivChg(preDivChg),
    .stepCmd  (stepCmd),
    .strobe   (strobe),
    .lockPinQ (lockPin),
    .lockBitQ (lockBit)
  );

endmodule

// File: rtl/lock_qual_checker.sv
module lock_qual_checker (
  input logic sysClk,
  input logic rst,
  input logic lockPin,
  input logic lockBit,
  input logic fbDivChg,
  input logic preDivChg,
  input logic stepCmd,
  input logic refLost,
  input logic rawOk,
  input logic qualLast
);

  // R1
  a_r1_pin_equals_bit: assert property (@(posedge sysClk) disable iff (rst)
    lockPin == lockBit);

  // R2
  a_r2_rise_after_count: assert property (@(posedge sysClk) disable iff (rst)
    $rose(lockPin) |-> $past(qualLast));

  // R4
  a_r4_raw_drop_clears: assert property (@(posedge sysClk) disable iff (rst)
    !rawOk |=> !lockPin);

  // R5
  a_r5_fbdiv_clears: assert property (@(posedge sysClk) disable iff (rst)
    fbDivChg |=> !lockPin);

  // R6
  a_r6_prediv_clears: assert property (@(posedge sysClk) disable iff (rst)
    preDivChg |=> !lockPin);

  // R7
  a_r7_step_clears: assert property (@(posedge sysClk) disable iff (rst)
    stepCmd |=> !lockPin);

  // R8
  a_r8_ref_lost_clears: assert property (@(posedge sysClk) disable iff (rst)
    refLost |=> !lockPin);

  // R10
  always @(posedge sysClk) begin
    if (rst) a_r10_reset_low: assert (!lockPin && !lockBit);
  end

endmodule

bind pll_lock_qualifier lock_qual_checker u_chk (
  .sysClk   (sysClk),
  .rst      (rst),
  .lockPin  (lockPin),
  .lockBit  (lockBit),
  .fbDivChg (fbDivChg),
  .preDivChg(preDivChg),
  .stepCmd  (stepCmd),
  .refLost  (dpStat.refLost),
  .rawOk    (dpStat.rawOk),
  .qualLast (dpStat.qualLast)
);

// File: tb/sim_pll_lock_qualifier.sv
`timescale 1ns/1ps
module sim_pll_lock_qualifier;

  localparam int Q  = 16;
  localparam int WD = 16;
  localparam int P  = 8;            // reference period in sysClk cycles
  localparam int LO = (Q - 1) * P;  // lock must still be low here
  localparam int HI = (Q + 1) * P + 4; // lock must be high here

  logic sysClk = 1'b0;
  logic refClk = 1'b0;
  logic rst = 1'b1;
  logic rawLock = 1'b0;
  logic fbDivChg = 1'b0, preDivChg = 1'b0, stepCmd = 1'b0;
  logic lockPin, lockBit;

  int checks = 0, fails = 0, r1Bad = 0, cyc = 0;
  logic refRun = 1'b0;
  int refPh = 0;
  bit done = 1'b0;

  always #10 sysClk = ~sysClk;  // 50 MHz

  pll_lock_qualifier #(.QUAL_CYCLES(Q), .WDOG_LIMIT(WD), .SYNC_STAGES(2)) u0 (
    .sysClk(sysClk), .refClk(refClk), .rst(rst), .rawLock(rawLock),
    .fbDivChg(fbDivChg), .preDivChg(preDivChg), .stepCmd(stepCmd),
    .lockPin(lockPin), .lockBit(lockBit)
  );

  // reference generator, changes on sysClk falling edges
  always @(negedge sysClk) begin
    if (!refRun) begin
      refPh  = 0;
      refClk = 1'b0;
    end else begin
      refPh  = (refPh + 1) % P;
      refClk = (refPh < P / 2);
    end
  end

  // R1 monitor
  always @(negedge sysClk) if (lockPin !== lockBit) r1Bad++;

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge sysClk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitSys(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic pulse(input int which);
    @(negedge sysClk);
    case (which)
      0: fbDivChg = 1'b1;
      1: preDivChg = 1'b1;
      default: stepCmd = 1'b1;
    endcase
    @(negedge sysClk);
    fbDivChg = 1'b0; preDivChg = 1'b0; stepCmd = 1'b0;
  endtask

  // called at the moment the lock conditions are restored; 'spent' cycles already gone
  task automatic expectRelock(input string tag, input int spent);
    waitSys(LO - spent);
    check(lockPin == 1'b0, {tag, " early"}, lockPin, 0);
    waitSys(HI - LO);
    check(lockPin == 1'b1, {tag, " relock"}, lockPin, 1);
  endtask

  task automatic getLocked();
    @(negedge sysClk);
    rawLock = 1'b1;
    waitSys(HI);
  endtask

  initial begin
    refRun = 1'b1;
    waitSys(3);
    // R10 reset state
    check(lockPin == 1'b0 && lockBit == 1'b0, "R10 reset state", lockPin, 0);
    rst = 1'b0;

    // R2 basic qualification
    @(negedge sysClk);
    rawLock = 1'b1;
    expectRelock("R2", 0);

    // R4 raw drop while locked
    @(negedge sysClk);
    rawLock = 1'b0;
    waitSys(4);
    check(lockPin == 1'b0, "R4 raw drop clears", lockPin, 0);
    waitSys(P);

    // R3 dropout swept over every reference position in the window
    for (int k = 1; k < Q; k++) begin
      @(negedge sysClk);
      rawLock = 1'b1;
      waitSys(k * P);
      rawLock = 1'b0;
      waitSys(P);
      rawLock = 1'b1;
      expectRelock($sformatf("R3 drop at %0d", k), 0);
      @(negedge sysClk);
      rawLock = 1'b0;
      waitSys(2 * P);
    end

    // R5 R6 R7 while locked, then automatic relock (R9)
    for (int ev = 0; ev < 3; ev++) begin
      string tag;
      tag = (ev == 0) ? "R5" : (ev == 1) ? "R6" : "R7";
      getLocked();
      check(lockPin == 1'b1, {tag, " precondition"}, lockPin, 1);
      pulse(ev);
      check(lockPin == 1'b0 && lockBit == 1'b0, {tag, " clears lock"}, lockPin, 0);
      expectRelock({tag, " R9"}, 1);
      @(negedge sysClk);
      rawLock = 1'b0;
      waitSys(2 * P);
    end

    // R5 R6 R7 restart swept across the qualification window
    for (int ev = 0; ev < 3; ev++) begin
      for (int k = 1; k < Q; k++) begin
        string tag;
        tag = (ev == 0) ? "R5" : (ev == 1) ? "R6" : "R7";
        @(negedge sysClk);
        rawLock = 1'b1;
        waitSys(k * P);
        pulse(ev);
        expectRelock($sformatf("%s restart at %0d", tag, k), 1);
        @(negedge sysClk);
        rawLock = 1'b0;
        waitSys(2 * P);
      end
    end

    // R8 reference stop, R9 recovery
    getLocked();
    refRun = 1'b0;
    waitSys(8);
    check(lockPin == 1'b1, "R8 one missing edge tolerated", lockPin, 1);
    waitSys(22);
    check(lockPin == 1'b0, "R8 two missing edges clear", lockPin, 0);
    refRun = 1'b1;
    expectRelock("R9 after ref return", 0);

    // R10 asynchronous reset while locked
    @(negedge sysClk);
    #3 rst = 1'b1;
    #1 check(lockPin == 1'b0 && lockBit == 1'b0, "R10 async reset", lockPin, 0);
    waitSys(2);
    rst = 1'b0;
    expectRelock("R10 after reset", 0);

    check(r1Bad == 0, "R1 pin equals bit", r1Bad, 0);
    finishRun();
  end

endmodule